// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is a single DMA channel that copies data units of one, two or four bytes between two places on a simple single-beat memory bus. Before a run, a load strobe captures a configuration: the start addresses, a 32-bit byte count, a repeat or block size, a unit size, a step rule for each address, the transfer mode, the request source and the addressing style. The load also enables the channel. Each request then moves one unit, or one whole block in block mode, until the byte count runs out. The channel then disables itself, sets a sticky done flag and pulses its interrupt.

Requests can come from three sources. The first is an automatic request, which runs in burst or in cycle-stealing fashion. The second is a one-cycle strobe from a peripheral. The third is an active-low external request line, which is synchronised and sensed either by level or by falling edge. In dual-address style each unit is a read beat followed by a write beat. In single-address style each unit is one beat, with the acknowledge output marking the device on the side that has no address. A repeat size field of zero stands for 65,536 units.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, memReq, dack, done, irq and chanActive are all low.
- R2: With cfgSingle=0, each unit is a read beat (memWe=0) at the source address, then a write beat (memWe=1) at the destination address that carries the data just read. memSize shows cfgUnit (0 byte, 1 word, 2 longword). Address and request hold steady until memAck.
- R3: After each unit, an address with step code 1 goes up by the unit size, step code 2 goes down by it, and step code 0 leaves it unchanged. The unit sizes are 1, 2 and 4 bytes.
- R4: cfgCount is a byte count that is lowered by the unit size per unit. When it reaches zero with cfgFreeRun=0, chanActive clears, done sets, and irq is high for exactly one cycle.
- R5: Once the channel has finished, no bus beat starts for any request until the next cfgLoad.
- R6: With cfgFreeRun=1, the count never ends the run: done and irq stay low and chanActive stays high.
- R7: With cfgActSrc=1, each periphReq pulse moves exactly one unit in normal mode (cfgMode=0).
- R8: With cfgActSrc=2, cfgDreqEdge=1 gives one unit per falling edge of dreqN. cfgDreqEdge=0 keeps starting units while dreqN is low and stops once it is high.
- R9: In repeat mode (cfgMode=1), after cfgRptSize units both addresses go back to their start values.
- R10: In block mode (cfgMode=2), one request moves cfgRptSize units back to back, and the addresses carry on from there on the next block.
- R11: With cfgSingle=1, each unit is one beat with dack high. cfgSingleDir=0 reads at the source address; cfgSingleDir=1 writes at the destination address.
- R12: With cfgActSrc=0, cfgBurst=1 keeps memReq high across units, and cfgBurst=0 drops memReq between units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLoad | input | 1 | Captures all cfg* inputs and enables the channel |
| cfgSrc | input | 32 | Source start address |
| cfgDst | input | 32 | Destination start address |
| cfgCount | input | 32 | Total byte count |
| cfgRptSize | input | 16 | Repeat/block size in units, 0 means 65,536 |
| cfgUnit | input | 2 | Unit: 0 byte, 1 word, 2 longword |
| cfgSrcStep | input | 2 | Source step: 0 fixed, 1 up, 2 down |
| cfgDstStep | input | 2 | Destination step: 0 fixed, 1 up, 2 down |
| cfgMode | input | 2 | 0 normal, 1 repeat, 2 block |
| cfgActSrc | input | 2 | 0 automatic, 1 peripheral, 2 external line |
| cfgBurst | input | 1 | Automatic request keeps the bus |
| cfgDreqEdge | input | 1 | 1 falling edge, 0 low level |
| cfgFreeRun | input | 1 | Ignore the byte count |
| cfgSingle | input | 1 | Single-address style |
| cfgSingleDir | input | 1 | Single style: 0 read source, 1 write destination |
| periphReq | input | 1 | Peripheral request strobe |
| dreqN | input | 1 | External request, active low |
| memReq | output | 1 | Bus beat request |
| memWe | output | 1 | Beat is a write |
| memAddr | output | 32 | Beat address |
| memSize | output | 2 | Beat unit code |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| memAck | input | 1 | Beat completes this cycle |
| dack | output | 1 | Acknowledge to the unaddressed device |
| chanActive | output | 1 | Channel enabled |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The directed tests target the wrap in repeat mode. A design that reloads one cycle late, or never reloads, keeps stepping on the fourth unit instead of going back to the start address. Edge sensing of the request line is held low for many cycles, so a design that treats the edge setting as a level request shows extra units. Block mode is fed a single request, so a design that stops after one unit, or runs past the block size, is caught by the beat count. The end of the count is checked for a single-cycle interrupt and for silence afterwards, and a design that ignores free-running stops early and raises done.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_REPEAT = 2'd1;
  localparam logic [1:0] MODE_BLOCK  = 2'd2;

  localparam logic [1:0] ACT_AUTO   = 2'd0;
  localparam logic [1:0] ACT_PERIPH = 2'd1;
  localparam logic [1:0] ACT_DREQ   = 2'd2;

  localparam logic [1:0] STEP_UP   = 2'd1;
  localparam logic [1:0] STEP_DOWN = 2'd2;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] actSrc;
    logic       burst;
    logic       dreqEdge;
    logic       freeRun;
    logic       single;
    logic       singleDir;
    logic [1:0] unit;
    logic [1:0] srcStep;
    logic [1:0] dstStep;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic blkStart;
    logic capRd;
    logic unitDone;
    logic selDst;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_SGL, ST_GAP
  } state_e;

endpackage

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] ldSrc,
  input  logic [AW-1:0] ldDst,
  input  logic [CW-1:0] ldCount,
  input  logic [RW-1:0] ldRpt,
  input  logic [1:0]    unit,
  input  logic [1:0]    srcStep,
  input  logic [1:0]    dstStep,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          lastUnit,
  output logic          blkLast
);

  localparam int SW = RW + 1;

  logic [AW-1:0] srcStart, dstStart, srcCur, dstCur;
  logic [CW-1:0] cnt;
  logic [SW-1:0] rptLoad, rptLeft, blkLeft;
  logic [DW-1:0] dataBuf;
  logic [2:0]    unitBytes;
  logic [SW-1:0] ldRptExp;

  always_comb begin
    unique case (unit)
      2'd0:    unitBytes = 3'd1;
      2'd1:    unitBytes = 3'd2;
      default: unitBytes = 3'd4;
    endcase
  end

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] cur,
                                             input logic [1:0] rule,
                                             input logic [2:0] ub);
    logic [AW-1:0] delta;
    delta = {{(AW-3){1'b0}}, ub};
    if (rule == STEP_UP)        stepAddr = cur + delta;
    else if (rule == STEP_DOWN) stepAddr = cur - delta;
    else                        stepAddr = cur;
  endfunction

  assign ldRptExp = (ldRpt == '0) ? {1'b1, {RW{1'b0}}} : {1'b0, ldRpt};
  assign lastUnit = (cnt <= {{(CW-3){1'b0}}, unitBytes});
  assign blkLast  = (blkLeft <= {{(SW-1){1'b0}}, 1'b1});
  assign busAddr  = stb.selDst ? dstCur : srcCur;
  assign busWdata = dataBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcStart <= '0;
      dstStart <= '0;
      srcCur   <= '0;
      dstCur   <= '0;
      cnt      <= '0;
      rptLoad  <= '0;
      rptLeft  <= '0;
      blkLeft  <= '0;
      dataBuf  <= '0;
    end else if (stb.load) begin
      srcStart <= ldSrc;
      dstStart <= ldDst;
      srcCur   <= ldSrc;
      dstCur   <= ldDst;
      cnt      <= ldCount;
      rptLoad  <= ldRptExp;
      rptLeft  <= ldRptExp;
      blkLeft  <= ldRptExp;
    end else begin
      if (stb.capRd)    dataBuf <= memRdata;
      if (stb.blkStart) blkLeft <= rptLoad;
      if (stb.unitDone) begin
        cnt <= cnt - {{(CW-3){1'b0}}, unitBytes};
        if (mode == MODE_BLOCK) blkLeft <= blkLeft - 1'b1;
        if (mode == MODE_REPEAT && rptLeft == {{(SW-1){1'b0}}, 1'b1}) begin
          srcCur  <= srcStart;
          dstCur  <= dstStart;
          rptLeft <= rptLoad;
        end else begin
          srcCur <= stepAddr(srcCur, srcStep, unitBytes);
          dstCur <= stepAddr(dstCur, dstStep, unitBytes);
          if (mode == MODE_REPEAT) rptLeft <= rptLeft - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgLoad,
  input  cfg_t    cfgIn,
  input  logic    periphReq,
  input  logic    dreqN,
  input  logic    memAck,
  input  logic    lastUnit,
  input  logic    blkLast,
  output cfg_t    cfgQ,
  output strobe_t stb,
  output logic    memReq,
  output logic    memWe,
  output logic    dack,
  output logic    chanActive,
  output logic    done,
  output logic    irq
);

  state_e state, stateNxt;
  logic dreqMeta, dreqSync, dreqPrev, pending;
  logic en, reqNow, startNow, unitEnd, finish, dreqFall;
  state_e firstSt;

  assign dreqFall = dreqPrev & ~dreqSync;
  assign reqNow   = (cfgQ.actSrc == ACT_AUTO) | pending |
                    ((cfgQ.actSrc == ACT_DREQ) & ~cfgQ.dreqEdge & ~dreqSync);
  assign startNow = (state == ST_IDLE) & en & reqNow;
  assign firstSt  = cfgQ.single ? ST_SGL : ST_RD;
  assign unitEnd  = ((state == ST_WR) | (state == ST_SGL)) & memAck;
  assign finish   = unitEnd & lastUnit & ~cfgQ.freeRun;

  assign memReq = (state == ST_RD) | (state == ST_WR) | (state == ST_SGL);
  assign memWe  = (state == ST_WR) | ((state == ST_SGL) & cfgQ.singleDir);
  assign dack   = (state == ST_SGL);
  assign chanActive = en;

  always_comb begin
    stb.load     = cfgLoad;
    stb.blkStart = startNow & (cfgQ.mode == MODE_BLOCK);
    stb.capRd    = (state == ST_RD) & memAck;
    stb.unitDone = unitEnd;
    stb.selDst   = (state == ST_WR) | ((state == ST_SGL) & cfgQ.singleDir);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (startNow) stateNxt = firstSt;
      ST_RD:   if (memAck) stateNxt = ST_WR;
      ST_WR, ST_SGL: begin
        if (memAck) begin
          if (finish)                                            stateNxt = ST_IDLE;
          else if ((cfgQ.mode == MODE_BLOCK) && !blkLast)        stateNxt = firstSt;
          else if ((cfgQ.actSrc == ACT_AUTO) && cfgQ.burst)      stateNxt = firstSt;
          else if (cfgQ.actSrc == ACT_AUTO)                      stateNxt = ST_GAP;
          else                                                   stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cfgQ     <= '0;
      en       <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
      pending  <= 1'b0;
      dreqMeta <= 1'b1;
      dreqSync <= 1'b1;
      dreqPrev <= 1'b1;
    end else begin
      dreqMeta <= dreqN;
      dreqSync <= dreqMeta;
      dreqPrev <= dreqSync;
      irq      <= 1'b0;
      if (cfgLoad) begin
        cfgQ    <= cfgIn;
        en      <= 1'b1;
        done    <= 1'b0;
        pending <= 1'b0;
        state   <= ST_IDLE;
      end else begin
        state <= stateNxt;
        if (finish) begin
          en   <= 1'b0;
          done <= 1'b1;
          irq  <= 1'b1;
        end
        if (!en || finish) pending <= 1'b0;
        else if ((cfgQ.actSrc == ACT_PERIPH && periphReq) ||
                 (cfgQ.actSrc == ACT_DREQ && cfgQ.dreqEdge && dreqFall))
          pending <= 1'b1;
        else if (startNow) pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [AW-1:0] cfgSrc,
  input  logic [AW-1:0] cfgDst,
  input  logic [CW-1:0] cfgCount,
  input  logic [RW-1:0] cfgRptSize,
  input  logic [1:0]    cfgUnit,
  input  logic [1:0]    cfgSrcStep,
  input  logic [1:0]    cfgDstStep,
  input  logic [1:0]    cfgMode,
  input  logic [1:0]    cfgActSrc,
  input  logic          cfgBurst,
  input  logic          cfgDreqEdge,
  input  logic          cfgFreeRun,
  input  logic          cfgSingle,
  input  logic          cfgSingleDir,
  input  logic          periphReq,
  input  logic          dreqN,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [1:0]    memSize,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memAck,
  output logic          dack,
  output logic          chanActive,
  output logic          done,
  output logic          irq
);

  cfg_t    cfgIn, cfgQ;
  strobe_t stb;
  logic    lastUnit, blkLast;

  always_comb begin
    cfgIn.mode      = cfgMode;
    cfgIn.actSrc    = cfgActSrc;
    cfgIn.burst     = cfgBurst;
    cfgIn.dreqEdge  = cfgDreqEdge;
    cfgIn.freeRun   = cfgFreeRun;
    cfgIn.single    = cfgSingle;
    cfgIn.singleDir = cfgSingleDir;
    cfgIn.unit      = cfgUnit;
    cfgIn.srcStep   = cfgSrcStep;
    cfgIn.dstStep   = cfgDstStep;
  end

  assign memSize = cfgQ.unit;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn),
    .periphReq(periphReq), .dreqN(dreqN), .memAck(memAck),
    .lastUnit(lastUnit), .blkLast(blkLast), .cfgQ(cfgQ), .stb(stb),
    .memReq(memReq), .memWe(memWe), .dack(dack),
    .chanActive(chanActive), .done(done), .irq(irq)
  );

  dma_chan_dpath #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .ldSrc(cfgSrc), .ldDst(cfgDst), .ldCount(cfgCount), .ldRpt(cfgRptSize),
    .unit(cfgQ.unit), .srcStep(cfgQ.srcStep), .dstStep(cfgQ.dstStep),
    .mode(cfgQ.mode), .memRdata(memRdata),
    .busAddr(memAddr), .busWdata(memWdata),
    .lastUnit(lastUnit), .blkLast(blkLast)
  );

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic          dack,
  input logic          chanActive,
  input logic          done,
  input logic          irq
);

  // R4
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (done && !chanActive));

  // R5
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive |-> !memReq);

  // R2
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R11
  dack_in_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    dack |-> memReq);

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck),
  .memAddr(memAddr), .dack(dack), .chanActive(chanActive),
  .done(done), .irq(irq)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [31:0] cfgSrc = '0, cfgDst = '0, cfgCount = '0;
  logic [15:0] cfgRptSize = '0;
  logic [1:0]  cfgUnit = '0, cfgSrcStep = '0, cfgDstStep = '0, cfgMode = '0, cfgActSrc = '0;
  logic        cfgBurst = 1'b0, cfgDreqEdge = 1'b0, cfgFreeRun = 1'b0;
  logic        cfgSingle = 1'b0, cfgSingleDir = 1'b0;
  logic        periphReq = 1'b0, dreqN = 1'b1;
  logic        memReq, memWe, dack, chanActive, done, irq;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic [1:0]  memSize;
  logic        memAck = 1'b0;

  int checks = 0, errors = 0;
  int logN = 0, irqCnt = 0, reqFalls = 0;
  logic [31:0] logAddr [0:63];
  logic [31:0] logData [0:63];
  logic        logWe   [0:63];
  logic        logDack [0:63];
  logic [1:0]  logSize [0:63];
  logic        prevReq = 1'b0;

  always #5 clk = ~clk;

  dma_chan_engine u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .cfgCount(cfgCount), .cfgRptSize(cfgRptSize), .cfgUnit(cfgUnit),
    .cfgSrcStep(cfgSrcStep), .cfgDstStep(cfgDstStep), .cfgMode(cfgMode),
    .cfgActSrc(cfgActSrc), .cfgBurst(cfgBurst), .cfgDreqEdge(cfgDreqEdge),
    .cfgFreeRun(cfgFreeRun), .cfgSingle(cfgSingle), .cfgSingleDir(cfgSingleDir),
    .periphReq(periphReq), .dreqN(dreqN), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .dack(dack), .chanActive(chanActive), .done(done), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // bus model: acknowledges every beat after one wait cycle, logs it
  always @(negedge clk) begin
    if (rstN && memReq && !memAck) begin
      memAck <= 1'b1;
      memRdata <= pat(memAddr);
      if (logN < 64) begin
        logAddr[logN] = memAddr;
        logData[logN] = memWdata;
        logWe[logN]   = memWe;
        logDack[logN] = dack;
        logSize[logN] = memSize;
      end
      logN = logN + 1;
    end else begin
      memAck <= 1'b0;
    end
    if (irq) irqCnt = irqCnt + 1;
    if (prevReq && !memReq) reqFalls = reqFalls + 1;
    prevReq = memReq;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    cfgLoad = 0; periphReq = 0; dreqN = 1;
    cfgSrc = 0; cfgDst = 0; cfgCount = 0; cfgRptSize = 0; cfgUnit = 0;
    cfgSrcStep = 0; cfgDstStep = 0; cfgMode = 0; cfgActSrc = 0;
    cfgBurst = 0; cfgDreqEdge = 0; cfgFreeRun = 0; cfgSingle = 0; cfgSingleDir = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    logN = 0; irqCnt = 0; reqFalls = 0;
    @(negedge clk);
  endtask

  task automatic load();
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic waitDone(input int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input int gap);
    periphReq = 1'b1;
    @(negedge clk);
    periphReq = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic tReset();
    resetDut();
    chkEq("R1 memReq", memReq, 0);
    chkEq("R1 dack", dack, 0);
    chkEq("R1 done", done, 0);
    chkEq("R1 irq", irq, 0);
    chkEq("R1 chanActive", chanActive, 0);
  endtask

  task automatic tDualBurst();
    resetDut();
    cfgSrc = 32'h1000; cfgDst = 32'h2000; cfgCount = 8; cfgUnit = 1;
    cfgSrcStep = 1; cfgDstStep = 2; cfgActSrc = 0; cfgBurst = 1;
    load();
    waitDone(200);
    chkEq("R4 beat count", logN, 8);
    for (int i = 0; i < 4; i++) begin
      chkEq("R2 read we", logWe[2*i], 0);
      chkEq("R3 src up", logAddr[2*i], 32'h1000 + 2*i);
      chkEq("R2 write we", logWe[2*i+1], 1);
      chkEq("R3 dst down", logAddr[2*i+1], 32'h2000 - 2*i);
      chkEq("R2 write data", logData[2*i+1], pat(32'h1000 + 2*i));
      chkEq("R2 size", logSize[2*i], 1);
    end
    chkEq("R4 irq pulses", irqCnt, 1);
    chkEq("R4 done", done, 1);
    chkEq("R4 active cleared", chanActive, 0);
    chkEq("R12 burst one release", reqFalls, 1);
    // R5: channel finished, automatic request still selected
    cfgActSrc = 1;
    strobe(10);
    repeat (30) @(negedge clk);
    chkEq("R5 no beats after end", logN, 8);
    chkEq("R5 memReq", memReq, 0);
  endtask

  task automatic tSteal();
    resetDut();
    cfgSrc = 32'h700; cfgDst = 32'hA00; cfgCount = 12; cfgUnit = 2;
    cfgSrcStep = 0; cfgDstStep = 1; cfgActSrc = 0; cfgBurst = 0;
    load();
    waitDone(200);
    chkEq("R12 steal beats", logN, 6);
    chkEq("R12 steal releases", reqFalls, 3);
    for (int i = 0; i < 3; i++) begin
      chkEq("R3 src fixed", logAddr[2*i], 32'h700);
      chkEq("R3 dst long step", logAddr[2*i+1], 32'hA00 + 4*i);
    end
  endtask

  task automatic tPeriph();
    resetDut();
    cfgSrc = 32'h40; cfgDst = 32'h80; cfgCount = 100; cfgUnit = 0;
    cfgSrcStep = 1; cfgDstStep = 1; cfgActSrc = 1;
    load();
    repeat (3) strobe(20);
    chkEq("R7 one unit per strobe", logN, 6);
    chkEq("R7 third src", logAddr[4], 32'h42);
    chkEq("R7 not done", done, 0);
  endtask

  task automatic tDreqEdge();
    resetDut();
    cfgSrc = 32'h10; cfgDst = 32'h20; cfgCount = 100; cfgActSrc = 2; cfgDreqEdge = 1;
    load();
    for (int k = 0; k < 2; k++) begin
      dreqN = 0; repeat (40) @(negedge clk);
      dreqN = 1; repeat (10) @(negedge clk);
    end
    chkEq("R8 edge units", logN, 4);
  endtask

  task automatic tDreqLevel();
    int n1;
    resetDut();
    cfgSrc = 32'h10; cfgDst = 32'h20; cfgCount = 1000; cfgActSrc = 2; cfgDreqEdge = 0;
    load();
    dreqN = 0; repeat (30) @(negedge clk);
    dreqN = 1; repeat (30) @(negedge clk);
    n1 = logN;
    chk(n1 >= 6, "R8 level repeats", n1, 6);
    repeat (30) @(negedge clk);
    chkEq("R8 level stops", logN, n1);
  endtask

  task automatic tRepeat();
    resetDut();
    cfgSrc = 32'h100; cfgDst = 32'h300; cfgCount = 100; cfgUnit = 0;
    cfgSrcStep = 1; cfgDstStep = 1; cfgMode = 1; cfgRptSize = 3; cfgActSrc = 1;
    load();
    repeat (5) strobe(15);
    chkEq("R9 beats", logN, 10);
    chkEq("R9 src u2", logAddr[4], 32'h102);
    chkEq("R9 src wrap", logAddr[6], 32'h100);
    chkEq("R9 dst wrap", logAddr[7], 32'h300);
    chkEq("R9 src after wrap", logAddr[8], 32'h101);
  endtask

  task automatic tBlock();
    resetDut();
    cfgSrc = 32'h400; cfgDst = 32'h800; cfgCount = 1000; cfgUnit = 2;
    cfgSrcStep = 1; cfgDstStep = 1; cfgMode = 2; cfgRptSize = 4; cfgActSrc = 1;
    load();
    strobe(50);
    chkEq("R10 one block", logN, 8);
    chkEq("R10 last src", logAddr[6], 32'h40C);
    chkEq("R10 back to back", reqFalls, 1);
    strobe(50);
    chkEq("R10 second block", logN, 16);
    chkEq("R10 continues", logAddr[8], 32'h410);
  endtask

  task automatic tSingle();
    resetDut();
    cfgSrc = 32'h50; cfgDst = 32'h90; cfgCount = 2; cfgUnit = 0;
    cfgSrcStep = 1; cfgDstStep = 2; cfgSingle = 1; cfgSingleDir = 0; cfgBurst = 1;
    load();
    waitDone(100);
    chkEq("R11 beats dir0", logN, 2);
    chkEq("R11 dack", logDack[0], 1);
    chkEq("R11 read", logWe[1], 0);
    chkEq("R11 src addr", logAddr[1], 32'h51);
    resetDut();
    cfgSrc = 32'h50; cfgDst = 32'h90; cfgCount = 2; cfgUnit = 0;
    cfgSrcStep = 1; cfgDstStep = 2; cfgSingle = 1; cfgSingleDir = 1; cfgBurst = 1;
    load();
    waitDone(100);
    chkEq("R11 beats dir1", logN, 2);
    chkEq("R11 write", logWe[0], 1);
    chkEq("R11 dack dir1", logDack[1], 1);
    chkEq("R11 dst addr", logAddr[1], 32'h8F);
  endtask

  task automatic tFree();
    resetDut();
    cfgSrc = 32'h0; cfgDst = 32'h200; cfgCount = 2; cfgUnit = 0;
    cfgSrcStep = 1; cfgDstStep = 1; cfgActSrc = 1; cfgFreeRun = 1;
    load();
    repeat (4) strobe(15);
    chkEq("R6 units past count", logN, 8);
    chkEq("R6 no done", done, 0);
    chkEq("R6 no irq", irqCnt, 0);
    chkEq("R6 still active", chanActive, 1);
  endtask

  initial begin
    tReset();
    tDualBurst();
    tSteal();
    tPeriph();
    tDreqEdge();
    tDreqLevel();
    tRepeat();
    tBlock();
    tSingle();
    tFree();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule